// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit channel of a three-channel interval timer. It counts ticks of a count-clock enable, takes a new count through a load strobe and a mode through a control strobe, and drives a readable count and an output pin. Six operating modes are provided: two one-shot modes, a periodic rate generator, a square-wave generator and two strobe modes. Each mode has its own rule for how the gate input affects counting.

Bus decoding, control-word parsing and read latching belong to a companion register block. That block drives `ctl_we`/`ctl_mode` and `load_we`/`load_value` and samples `count_o`. Counting is binary only. Internally the channel tracks the ticks elapsed since the last load or restart. It derives the readable count and the output level from that elapsed value, the phase within the period, and the loaded limit.

Top module: `timer_channel`

## Requirements
- R1: After reset `out_o` is 0 and `count_o` is 0. `out_o` stays 0, and loaded counts do not advance, until the first control strobe.
- R2: A load value of 0 acts as a limit of 65536 ticks. `count_o` reads 0 right after such a load, and in mode 0 `out_o` rises after exactly 65536 ticks.
- R3: A load sets elapsed ticks to 0 and starts counting. `count_o` shows the new value in the following cycle, and the next `tick_en` advances it. A load taken while counting restarts from the new value.
- R4: Mode 0 (`ctl_mode`=0): `out_o` is 1 once elapsed ticks reach the limit and then stays 1. In modes 0 and 4, `gate`=0 freezes counting and `gate`=1 resumes it.
- R5: Mode 1: `out_o` is 0 while elapsed ticks are below the limit and 1 from expiry on. The `gate` level does not pause counting.
- R6: Mode 2 repeats with a period equal to the limit. `out_o` is 1 for one tick each time elapsed ticks reach a non-zero multiple of the limit, but not at load, and `count_o` then reads the limit.
- R7: Mode 3: `out_o` is 1 while (elapsed mod limit) < (limit+1)/2, otherwise 0. `count_o` = limit − ((2·elapsed) mod limit), so it falls by two per tick.
- R8: Modes 4 and 5 give a single one-tick `out_o` strobe when elapsed ticks equal the limit, while `count_o` reads 0.
- R9: In modes 0, 1, 4 and 5, `count_o` = (limit − elapsed) mod 65536, so it wraps through 0xFFFF after expiry instead of reloading.
- R10: In modes 1, 2, 3 and 5, a 0→1 change of `gate` sets elapsed ticks to 0 on that clock.
- R11: A control strobe with `ctl_mode` 6 or 7 selects mode 2 or 3. Any control strobe stops counting and zeroes elapsed ticks until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-clock enable, one pulse per tick |
| gate | input | 1 | Gate, synchronous to clk |
| ctl_we | input | 1 | Control strobe, takes `ctl_mode` |
| ctl_mode | input | 3 | Mode number 0–7 (6, 7 alias 2, 3) |
| load_we | input | 1 | Load strobe, takes `load_value` |
| load_value | input | 16 | Count value, 0 means 65536 |
| count_o | output | 16 | Current readable count |
| out_o | output | 1 | Channel output pin |

## Verification
The assertions assume that `ctl_we` and `load_we` are never high in the same cycle and that `gate` is already synchronous to `clk`. Under those assumptions, the stable-count check for a paused gate and the zero-count check for a strobe rely only on the documented priority. The stimulus drives every input at the falling edge, raises at most one strobe per cycle, and uses tick patterns of one pulse per cycle and one per several cycles. This keeps elapsed values well below the 2^17 lap point.

// File: rtl/timer_channel_pkg.sv
package timer_channel_pkg;

  typedef enum logic [2:0] {
    TM_ONESHOT_SW = 3'd0,
    TM_ONESHOT_HW = 3'd1,
    TM_RATE       = 3'd2,
    TM_SQUARE     = 3'd3,
    TM_STROBE_SW  = 3'd4,
    TM_STROBE_HW  = 3'd5
  } tmode_e;

  // codes 6 and 7 fold onto the periodic modes
  function automatic tmode_e remap_mode(input logic [2:0] raw);
    if (raw > 3'd5) return tmode_e'(raw - 3'd4);
    return tmode_e'(raw);
  endfunction

  function automatic logic gate_retriggers(input tmode_e m);
    return (m == TM_ONESHOT_HW) || (m == TM_RATE) ||
           (m == TM_SQUARE) || (m == TM_STROBE_HW);
  endfunction

  function automatic logic gate_pauses(input tmode_e m);
    return (m == TM_ONESHOT_SW) || (m == TM_STROBE_SW);
  endfunction

endpackage

// File: rtl/tc_gate_ctl.sv
module tc_gate_ctl
  import timer_channel_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick_en,
  input  logic   gate,
  input  tmode_e mode,
  input  logic   mode_valid,
  input  logic   running,
  output logic   restart,
  output logic   advance
);

  logic gate_q;
  logic gate_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  assign gate_rise = gate & ~gate_q;
  assign restart   = gate_rise & mode_valid & gate_retriggers(mode);
  assign advance   = tick_en & mode_valid & running &
                     ~(gate_pauses(mode) & ~gate);

  // R4
  pause_no_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_valid && gate_pauses(mode) && !gate) |-> !advance);

endmodule

// File: rtl/tc_elapsed.sv
module tc_elapsed #(
  parameter int EW = 17,
  parameter int NW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          advance,
  input  logic [NW-1:0] limit,
  output logic [EW-1:0] elapsed,
  output logic [NW-1:0] phase,
  output logic          started,
  output logic          reached,
  output logic          lapped
);

  logic [EW-1:0] elapsed_nx;
  logic [NW-1:0] phase_nx;

  assign elapsed_nx = elapsed + 1'b1;
  assign phase_nx   = (phase == limit - 1'b1) ? '0 : phase + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      elapsed <= '0;
      phase   <= '0;
      started <= 1'b0;
      reached <= 1'b0;
      lapped  <= 1'b0;
    end else if (advance) begin
      elapsed <= elapsed_nx;
      phase   <= phase_nx;
      started <= 1'b1;
      reached <= reached | (NW'(elapsed_nx) == limit);
      lapped  <= lapped | (&elapsed);
    end
  end

  // R7
  phase_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase < limit);

  // R4
  reached_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reached && !clear) |=> reached);

endmodule

// File: rtl/tc_decode.sv
module tc_decode
  import timer_channel_pkg::*;
#(
  parameter int CW = 16,
  localparam int NW = CW + 1,
  localparam int EW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tmode_e        mode,
  input  logic          mode_valid,
  input  logic [NW-1:0] limit,
  input  logic [EW-1:0] elapsed,
  input  logic [NW-1:0] phase,
  input  logic          started,
  input  logic          reached,
  input  logic          lapped,
  output logic [CW-1:0] count_o,
  output logic          out_o
);

  // (2*phase) mod limit, phase already below limit
  function automatic logic [NW-1:0] fold_double(input logic [NW-1:0] ph,
                                                input logic [NW-1:0] lim);
    logic [NW:0] dbl;
    dbl = {ph, 1'b0};
    if (dbl >= {1'b0, lim}) dbl = dbl - {1'b0, lim};
    return dbl[NW-1:0];
  endfunction

  function automatic logic [NW-1:0] half_up(input logic [NW-1:0] lim);
    logic [NW:0] s;
    s = {1'b0, lim} + 1'b1;
    return s[NW:1];
  endfunction

  function automatic logic [CW-1:0] remaining(input logic [NW-1:0] lim,
                                              input logic [NW-1:0] used);
    return CW'(lim - used);
  endfunction

  logic out_raw;

  always_comb begin
    case (mode)
      TM_RATE:   count_o = remaining(limit, phase);
      TM_SQUARE: count_o = remaining(limit, fold_double(phase, limit));
      default:   count_o = remaining(limit, NW'(elapsed));
    endcase
  end

  always_comb begin
    case (mode)
      TM_ONESHOT_SW, TM_ONESHOT_HW: out_raw = reached;
      TM_RATE:                      out_raw = started && (phase == '0);
      TM_SQUARE:                    out_raw = phase < half_up(limit);
      default:                      out_raw = !lapped && (NW'(elapsed) == limit);
    endcase
  end

  assign out_o = mode_valid & out_raw;

  // R6
  rate_pulse_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_RATE && out_o) |-> (count_o == limit[CW-1:0]));

  // R8
  strobe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == TM_STROBE_SW || mode == TM_STROBE_HW) && out_o) |-> (count_o == '0));

endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import timer_channel_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          gate,
  input  logic          ctl_we,
  input  logic [2:0]    ctl_mode,
  input  logic          load_we,
  input  logic [CW-1:0] load_value,
  output logic [CW-1:0] count_o,
  output logic          out_o
);

  localparam int NW = CW + 1;
  localparam int EW = CW + 1;
  localparam logic [NW-1:0] FULL_LIMIT = {1'b1, {CW{1'b0}}};

  tmode_e        mode_q;
  logic          valid_q;
  logic          running_q;
  logic [NW-1:0] limit_q;

  logic          restart;
  logic          advance;
  logic          clear;
  logic [EW-1:0] elapsed;
  logic [NW-1:0] phase;
  logic          started;
  logic          reached;
  logic          lapped;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= TM_ONESHOT_SW;
      valid_q   <= 1'b0;
      running_q <= 1'b0;
      limit_q   <= FULL_LIMIT;
    end else if (ctl_we) begin
      mode_q    <= remap_mode(ctl_mode);
      valid_q   <= 1'b1;
      running_q <= 1'b0;
    end else if (load_we) begin
      limit_q   <= (load_value == '0) ? FULL_LIMIT : {1'b0, load_value};
      running_q <= 1'b1;
    end
  end

  assign clear = ctl_we | load_we | restart;

  tc_gate_ctl u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .gate       (gate),
    .mode       (mode_q),
    .mode_valid (valid_q),
    .running    (running_q),
    .restart    (restart),
    .advance    (advance)
  );

  tc_elapsed #(.EW(EW), .NW(NW)) u_elapsed (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .advance (advance),
    .limit   (limit_q),
    .elapsed (elapsed),
    .phase   (phase),
    .started (started),
    .reached (reached),
    .lapped  (lapped)
  );

  tc_decode #(.CW(CW)) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode_q),
    .mode_valid (valid_q),
    .limit      (limit_q),
    .elapsed    (elapsed),
    .phase      (phase),
    .started    (started),
    .reached    (reached),
    .lapped     (lapped),
    .count_o    (count_o),
    .out_o      (out_o)
  );

  // R1
  unset_mode_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> !out_o);

  // R2
  zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_we && !ctl_we && load_value == '0) |=> (count_o == '0));

  // R4
  gate_pause_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && (mode_q == TM_ONESHOT_SW || mode_q == TM_STROBE_SW) &&
     !gate && !ctl_we && !load_we) |=> $stable(count_o));

  // R11
  ctl_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !load_we) |=> (elapsed == '0 && !running_q));

endmodule

// File: tb/test_timer_channel.sv
module test_timer_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        gate = 1'b0;
  logic        ctl_we = 1'b0;
  logic [2:0]  ctl_mode = 3'd0;
  logic        load_we = 1'b0;
  logic [15:0] load_value = 16'd0;
  logic [15:0] count_o;
  logic        out_o;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  logic cur_gate = 1'b0;

  // reference state
  int     m_mode = 0;
  bit     m_valid = 0;
  bit     m_running = 0;
  longint m_n = 65536;
  longint m_d = 0;
  bit     m_gprev = 0;

  always #10 clk = ~clk;

  timer_channel i_timer_channel (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate),
    .ctl_we(ctl_we), .ctl_mode(ctl_mode), .load_we(load_we),
    .load_value(load_value), .count_o(count_o), .out_o(out_o)
  );

  function automatic longint wrap16(input longint v);
    return ((v % 65536) + 65536) % 65536;
  endfunction

  function automatic longint exp_count();
    case (m_mode)
      2: return wrap16(m_n - (m_d % m_n));
      3: return wrap16(m_n - ((2 * m_d) % m_n));
      default: return wrap16(m_n - m_d);
    endcase
  endfunction

  function automatic bit exp_out();
    if (!m_valid) return 0;
    case (m_mode)
      0, 1: return m_d >= m_n;
      2: return (m_d % m_n == 0) && (m_d != 0);
      3: return (m_d % m_n) < (m_n + 1) / 2;
      default: return m_d == m_n;
    endcase
  endfunction

  task automatic compare();
    longint ec;
    bit eo;
    ec = exp_count();
    eo = exp_out();
    checks++;
    if (longint'(count_o) != ec || out_o != eo) begin
      fails++;
      $display("FAIL %s: count=%0h out=%0b expected count=%0h out=%0b",
               cur_req, count_o, out_o, ec, eo);
    end
  endtask

  task automatic cyc(input bit tk, input bit cw, input int cm,
                     input bit lw, input int lv);
    bit gedge;
    tick_en = tk; gate = cur_gate; ctl_we = cw; ctl_mode = 3'(cm);
    load_we = lw; load_value = 16'(lv);
    gedge = cur_gate && !m_gprev;
    m_gprev = cur_gate;
    if (cw) begin
      m_mode = (cm > 5) ? cm - 4 : cm;
      m_valid = 1; m_running = 0; m_d = 0;
    end else if (lw) begin
      m_n = (lv == 0) ? 65536 : lv;
      m_running = 1; m_d = 0;
    end else if (gedge && m_valid && (m_mode == 1 || m_mode == 2 ||
                                      m_mode == 3 || m_mode == 5)) begin
      m_d = 0;
    end else if (tk && m_valid && m_running &&
                 !((m_mode == 0 || m_mode == 4) && !cur_gate)) begin
      m_d++;
    end
    @(negedge clk);
    compare();
  endtask

  task automatic run(input int n, input int div);
    for (int i = 0; i < n; i++) cyc((i % div) == 0, 0, 0, 0, 0);
  endtask

  task automatic set_mode(input int m);
    cyc(0, 1, m, 0, 0);
  endtask

  task automatic load(input int v);
    cyc(0, 0, 0, 1, v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, then load without a mode
    cur_req = "R1";
    compare();
    load(5);
    run(8, 1);

    // R4: mode 0 with gate pause
    cur_req = "R4";
    cur_gate = 1;
    set_mode(0);
    load(10);
    run(6, 1);
    cur_gate = 0; run(5, 1);
    cur_gate = 1; run(8, 1);
    // R9: wrap after expiry
    cur_req = "R9";
    run(6, 1);
    // R3: reload while running
    cur_req = "R3";
    load(20); run(5, 1); load(7); run(4, 3);

    // R5 and R10: mode 1, level ignored, rising edge restarts
    cur_req = "R5";
    set_mode(1);
    load(6);
    run(3, 1);
    cur_gate = 0; run(4, 1);
    cur_req = "R10";
    cur_gate = 1; run(10, 1);
    cur_req = "R9";
    run(4, 1);

    // R6: rate generator with slow ticks
    cur_req = "R6";
    set_mode(2);
    load(4);
    run(20, 2);
    cur_req = "R10";
    cur_gate = 0; run(2, 1);
    cur_gate = 1; run(9, 1);

    // R7: square wave, odd then even
    cur_req = "R7";
    set_mode(3);
    load(5);
    run(14, 1);
    load(6);
    run(15, 1);

    // R8: strobes
    cur_req = "R8";
    set_mode(4);
    load(3);
    run(2, 1);
    cur_gate = 0; run(3, 1);
    cur_gate = 1; run(6, 1);
    set_mode(5);
    load(3);
    run(5, 1);
    cur_gate = 0; run(1, 1);
    cur_gate = 1; run(6, 1);

    // R11: aliases and control strobe stops counting
    cur_req = "R11";
    set_mode(6);
    run(3, 1);
    load(3);
    run(8, 1);
    set_mode(7);
    load(4);
    run(10, 1);
    set_mode(0);
    run(4, 1);

    // R2: zero load means 65536 ticks
    cur_req = "R2";
    load(0);
    run(65540, 1);
    set_mode(2);
    load(0);
    run(5, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule